// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable synchronous static RAM whose data phase trails its command phase by exactly one clock, whether the command reads or writes. Because both directions share that one-cycle spacing, a read can follow a write (or a write a read) on the very next edge with no idle bus cycle. Each word is 36 bits, split into four 9-bit lanes, and the depth is set by an address-width parameter.

A command is taken on a clock edge when clock enable is low, advance is low and all three chip selects are asserted. Read data is not registered on the way out: during the data cycle the output comes straight from the array at the current address. Write data and lane selects are sampled at the edge that closes the data cycle, and only the selected lanes are updated. Holding advance high after a command runs a four-beat burst from the loaded address, in linear or interleaved order. The bidirectional data pins are split into an input bus, an output bus and an active-high drive enable. An active-low asynchronous output enable gates that drive enable.

Top module: `zbt_sram`

## Requirements
- R1: A read command accepted at an edge makes the following cycle a read data cycle: `dq_oe` is high and `dq_out` shows the stored word at the command address, taken combinationally from the array.
- R2: A write command accepted at an edge leaves `dq_oe` low for the following cycle. The lanes selected in that cycle are written from `dq_in` at the edge that ends it.
- R3: Commands may be issued on every edge in any mix of reads and writes. A read issued on the edge right after a write's data cycle begins returns the newly written data.
- R4: `bwe_n[i]` low during a write data cycle writes bits [9i+8:9i]. A lane whose bit is high keeps its old contents.
- R5: While `cke_n` is high, every synchronous input is ignored and all internal state holds. That includes any pending write, the burst position and the output bus.
- R6: The chip is selected only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. A load (`adv`=0) with any select inactive starts no operation, leaves `dq_oe` low in the next cycle and ends any burst. A write whose data cycle is already under way still commits.
- R7: `oe_n` high forces `dq_oe` low at once, with no clock edge needed, whatever the pipeline holds.
- R8: With `burst_linear`=1 captured at the load, each edge with `adv`=1 advances the burst. The two low address bits become (base+k) mod 4 for beat k, the upper bits stay fixed, and the order wraps after the fourth beat.
- R9: With `burst_linear`=0 captured at the load, the two low address bits of beat k become base XOR k.
- R10: After reset, and after any `adv`=1 edge with no burst running, no operation is pending and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cke_n | input | 1 | Clock enable, active low; high suspends the block |
| ce0_n | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| ce2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new command, 1 advances a running burst |
| wr_n | input | 1 | 0 write, 1 read (sampled at load) |
| bwe_n | input | 4 | Per-lane write selects, active low |
| burst_linear | input | 1 | 1 linear, 0 interleaved burst order (sampled at load) |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data bus |
| dq_out | output | 36 | Read data bus (flow-through) |
| dq_oe | output | 1 | Drive enable for the data pins |

## Verification
Every command result is due in the cycle right after the edge that accepts it. The bench drives inputs on the falling edge and samples 2 ns after the rising edge that takes the command, which is the read data cycle. Write data is supplied one row later and shows up only through a read issued at the same edge or after it. The output enable is the one result with no latency, so it is checked 1 ns after toggling `oe_n` with no clock edge in between.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke_n,
  input  logic                    ce0_n,
  input  logic                    ce1,
  input  logic                    ce2_n,
  input  logic                    adv,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        bwe_n,
  input  logic                    burst_linear,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic               act, op_wr, lin_q, brst;
  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] cnt;

  wire selected = !ce0_n && ce1 && !ce2_n;
  wire [BURST_W-1:0] low = lin_q ? base[BURST_W-1:0] + cnt : base[BURST_W-1:0] ^ cnt;
  wire [ADDR_W-1:0]  cur = {base[ADDR_W-1:BURST_W], low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      brst  <= 1'b0;
      op_wr <= 1'b0;
      lin_q <= 1'b0;
      base  <= '0;
      cnt   <= '0;
    end else if (!cke_n) begin
      if (!adv) begin
        act  <= selected;
        brst <= selected;
        if (selected) begin
          op_wr <= !wr_n;
          base  <= addr;
          lin_q <= burst_linear;
          cnt   <= '0;
        end
      end else begin
        act <= brst;
        if (brst) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!cke_n && act && op_wr) begin
      for (int i = 0; i < LANES; i++)
        if (!bwe_n[i]) mem[cur][i*LANE_W +: LANE_W] <= dq_in[i*LANE_W +: LANE_W];
    end
  end

  assign dq_out = mem[cur];
  assign dq_oe  = act && !op_wr && !oe_n;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_n,
  input logic              ce0_n,
  input logic              ce1,
  input logic              ce2_n,
  input logic              adv,
  input logic              wr_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  wire sel_ok = !ce0_n && ce1 && !ce2_n;

  AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !dq_oe); // R7
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && sel_ok && wr_n) |=> (oe_n || dq_oe)); // R1
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && sel_ok && !wr_n) |=> !dq_oe); // R2
  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && !sel_ok) |=> !dq_oe); // R6
  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && !oe_n && dq_oe) |=> (oe_n || (dq_oe && $stable(dq_out)))); // R5
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
  .adv(adv), .wr_n(wr_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int VW = 90;
  localparam int NV = 28;

  localparam logic [2:0]  EN = 3'b010;
  localparam logic [2:0]  DS = 3'b110;
  localparam logic [35:0] A1 = 36'h123456789;
  localparam logic [35:0] B2 = 36'h9ABCDEF01;
  localparam logic [35:0] W0 = 36'h100000001;
  localparam logic [35:0] W1 = 36'h200000002;
  localparam logic [35:0] W2 = 36'h300000003;
  localparam logic [35:0] W3 = 36'h400000004;
  localparam logic [35:0] C3 = 36'h5A5A5A5A5;
  localparam logic [35:0] FF = 36'hFFFFFFFFF;
  localparam logic [35:0] LM = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
  localparam logic [35:0] MG = (A1 & ~LM) | (FF & LM);

  // {cke_n, ce0_n/ce1/ce2_n, adv, wr_n, lin, bwe_n, addr, din, exp_oe, exp_out}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, EN, 1'b0, 1'b0, 1'b1, 4'hF, 6'd4,  36'h0, 1'b0, 36'h0}, // R2 write cmd
    {1'b0, EN, 1'b0, 1'b0, 1'b1, 4'h0, 6'd5,  A1,    1'b0, 36'h0}, // R2 R3 write after write
    {1'b0, EN, 1'b0, 1'b1, 1'b1, 4'h0, 6'd4,  B2,    1'b1, A1},    // R1 R3 read after write
    {1'b0, EN, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5,  36'h0, 1'b1, B2},    // R1 R3
    {1'b0, EN, 1'b0, 1'b0, 1'b1, 4'hF, 6'd4,  36'h0, 1'b0, 36'h0}, // R2 read->write
    {1'b0, EN, 1'b0, 1'b1, 1'b1, 4'hA, 6'd4,  FF,    1'b1, MG},    // R4 R3 lanes 0,2
    {1'b1, EN, 1'b0, 1'b0, 1'b1, 4'h0, 6'd4,  36'h0, 1'b1, MG},    // R5 suspended
    {1'b0, DS, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b0, 36'h0}, // R6 deselect
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b0, 36'h0}, // R10 adv, no burst
    {1'b0, EN, 1'b0, 1'b0, 1'b1, 4'hF, 6'd8,  36'h0, 1'b0, 36'h0}, // R8 write burst
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'h0, 6'd0,  W0,    1'b0, 36'h0}, // R8
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'h0, 6'd0,  W1,    1'b0, 36'h0}, // R8
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'h0, 6'd0,  W2,    1'b0, 36'h0}, // R8
    {1'b0, EN, 1'b0, 1'b1, 1'b1, 4'h0, 6'd10, W3,    1'b1, W2},    // R8 linear read base 10
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b1, W3},    // R8 -> 11
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b1, W0},    // R8 -> 8
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b1, W1},    // R8 -> 9
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b1, W2},    // R8 wrap -> 10
    {1'b0, EN, 1'b0, 1'b1, 1'b0, 4'hF, 6'd9,  36'h0, 1'b1, W1},    // R9 interleaved base 9
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b1, W0},    // R9 -> 8
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b1, W3},    // R9 -> 11
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b1, W2},    // R9 -> 10
    {1'b0, DS, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b0, 36'h0}, // R6
    {1'b0, EN, 1'b0, 1'b0, 1'b1, 4'hF, 6'd12, 36'h0, 1'b0, 36'h0}, // R6 write then deselect
    {1'b0, DS, 1'b0, 1'b1, 1'b1, 4'h0, 6'd0,  C3,    1'b0, 36'h0}, // R6 pending write commits
    {1'b0, EN, 1'b0, 1'b1, 1'b1, 4'hF, 6'd12, 36'h0, 1'b1, C3},    // R6 read back
    {1'b0, DS, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b0, 36'h0}, // R6
    {1'b0, EN, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  36'h0, 1'b0, 36'h0}  // R6 burst ended
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke_n = 1'b0, ce0_n = 1'b1, ce1 = 1'b0, ce2_n = 1'b1;
  logic adv = 1'b1, wr_n = 1'b1, burst_linear = 1'b1, oe_n = 1'b0;
  logic [3:0]    bwe_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  zbt_sram u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
    .adv(adv), .wr_n(wr_n), .bwe_n(bwe_n), .burst_linear(burst_linear), .addr(addr),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R10 reset oe", {35'h0, dq_oe}, 36'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #2 check("R10 after reset", {35'h0, dq_oe}, 36'h0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cke_n, ce0_n, ce1, ce2_n, adv, wr_n, burst_linear, bwe_n, addr, dq_in} = VEC[i][VW-1:37];
      @(posedge clk);
      #2;
      check($sformatf("R%0d row %0d oe", 0, i), {35'h0, dq_oe}, {35'h0, VEC[i][36]});
      if (VEC[i][36]) check($sformatf("row %0d data", i), dq_out, VEC[i][35:0]);
    end
    // R7: asynchronous output enable during a read data cycle
    @(negedge clk);
    {ce0_n, ce1, ce2_n} = EN; adv = 1'b0; wr_n = 1'b1; addr = 6'd5; cke_n = 1'b0;
    @(posedge clk);
    #2 check("R7 drive before oe_n", {35'h0, dq_oe}, 36'h1);
    cke_n = 1'b1;
    oe_n = 1'b1;
    #1 check("R7 oe_n high", {35'h0, dq_oe}, 36'h0);
    oe_n = 1'b0;
    #1 check("R7 oe_n low again", {35'h0, dq_oe}, 36'h1);
    check("R1 R5 data held", dq_out, B2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule